// File: doc/BRIEF.md
# Debug Port Transmission Sequencer

This block is the serial front end of a debug controller. It sits between an external development host and a CPU that is halted in debug mode. The host sends framed serial transmissions. Each transmission holds a mode bit, a control bit and a payload word. The block hands instructions and data words to the CPU when the CPU asks for them. For every transmission it also shifts back a two-bit status code followed by a word. When the serial port is idle, the serial output carries a ready indication.

The block recovers from a mis-sequenced transfer with two latches. Suppose the host sends a data word while the CPU is waiting for an instruction. The CPU's access is then terminated with a bus error and the sequencing-error latch is set. The next transmission reports a sequencing error, and the one after it reports a CPU exception. The input of both of those transmissions is discarded. After that, normal transfers resume. An exception raised by the CPU itself, if its enable input is set, is reported in the same way and also ends the pending access with a bus error.

The serial clock is assumed to have already been brought into the core clock domain. Each rising edge of the serial clock appears as a one-cycle shift strobe.

Top module: `dbgport_seq`

## Requirements
- R1: After a synchronous active-low reset, both error latches are clear and no CPU word is pending. The first accepted transmission therefore reports the null status 2'b11 with an all-zero word.
- R2: A transmission begins with a start bit of 1, sampled at a shift strobe while the port is ready. Then follow, one per strobe: the mode bit, the control bit, and WORD_W payload bits, MSB first. The reply is 2 status bits and then WORD_W word bits, MSB first. Reply bit k is on sdo before the strobe that samples input bit k after the start bit.
- R3: Suppose the CPU waits for an instruction (request high, is_data 0) and a frame arrives with mode 0 and control 0. Two cycles after the last strobe, cpu_rsp_valid pulses for exactly one cycle, with cpu_rsp_word equal to the payload.
- R4: Suppose the CPU waits for a data word (is_data 1) and a frame arrives with mode 0 and control 1. The block answers the same way as in R3, with the payload.
- R5: A mode-0 frame whose control bit does not match the pending request kind produces a one-cycle cpu_bus_err and no response, and it sets the sequencing-error latch. The next transmission reports status 2'b01 with a zero word, discards its payload and causes no CPU response or bus error.
- R6: The transmission after a sequencing-error report reports status 2'b10, discards its payload and raises no bus error. The transmission after that is handled normally again, with null status.
- R7: A cpu_exc pulse while exc_enable is 1 makes the next transmission report status 2'b10 and discard its payload. If a CPU request is pending, that request ends with a one-cycle cpu_bus_err at the end of the transmission. A cpu_exc pulse while exc_enable is 0 has no effect.
- R8: A word written with cpu_wr_valid is reported by the next transmission as status 2'b00 followed by that word. The transmission after that reports null.
- R9: A frame with mode bit 1 is not forwarded to the CPU. It causes neither a response nor a bus error, and the pending request is still served by the next mode-0 frame.
- R10: While no transmission is in progress, sdo is the ready bit. Ready is 1 only when a CPU request is pending or an error latch is set, and only after the previous transmission's CPU response or bus error has been issued. Ready is 0 in the cycle after the last strobe. A start bit seen while ready is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | One-cycle strobe per rising serial-clock edge |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial reply, or the ready bit when idle |
| cpu_req_valid | input | 1 | CPU waits for a word from the port (held until answered) |
| cpu_req_is_data | input | 1 | 0: instruction fetch, 1: data read |
| cpu_rsp_valid | output | 1 | One-cycle pulse delivering cpu_rsp_word |
| cpu_rsp_word | output | WORD_W | Word handed to the CPU |
| cpu_bus_err | output | 1 | One-cycle pulse ending the CPU access with a bus error |
| cpu_wr_valid | input | 1 | CPU hands a word to the port for reporting |
| cpu_wr_word | input | WORD_W | Word written by the CPU |
| cpu_exc | input | 1 | Pulse: CPU took an exception in debug mode |
| exc_enable | input | 1 | Enable bit for reporting cpu_exc |

## Verification
The bench sweeps every combination of request kind, mode bit and control bit with several payload patterns. From that combination it computes whether a response, a bus error or a three-frame recovery must follow. A design that skipped a recovery stage, or did not discard the payload while reporting, would show a wrong status code or an unexpected response pulse in the frames that follow. Separate cases target the exception-enable gate and the difference between CPU-caused and sequencing-caused exception reports: a wrong design here would raise a spurious bus error in the third recovery frame. Two further cases cover a start bit arriving while not ready, which would misalign the next frame if accepted, and the ready bit staying low in the cycle right after a frame.

// File: rtl/dbgport_pkg.sv
// Package: shared status codes and frame geometry for the debug port.
// Assumes a 2-bit status header in front of each reply word.
package dbgport_pkg;
    typedef enum logic [1:0] {
        ST_DATA   = 2'b00,
        ST_SEQERR = 2'b01,
        ST_EXC    = 2'b10,
        ST_NULL   = 2'b11
    } dp_status_e;

    localparam int HDR_BITS = 2;
endpackage

// File: rtl/dbgport_frame_rx.sv
// Frame receiver: detects the start bit while the port is ready, then
// collects mode, control and payload bits, one per shift strobe.
// Assumes shift_en is a single-cycle strobe in the clk domain.
module dbgport_frame_rx #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdi,
    input  logic              ready,
    output logic              frame_start,
    output logic              busy,
    output logic              done,
    output logic              mode,
    output logic              ctrl,
    output logic [WORD_W-1:0] payload
);
    localparam int FRAME_BITS = WORD_W + dbgport_pkg::HDR_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sr_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  busy_q;
    logic                  done_q;

    // A start bit is taken only from an idle, ready port.
    assign frame_start = shift_en && !busy_q && sdi && ready;

    // Collect frame bits and flag the cycle after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (busy_q && shift_en) begin
                sr_q <= {sr_q[FRAME_BITS-2:0], sdi};
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign mode    = sr_q[FRAME_BITS-1];
    assign ctrl    = sr_q[FRAME_BITS-2];
    assign payload = sr_q[WORD_W-1:0];

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= LAST));

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/dbgport_tx.sv
// Reply shifter: loads status plus word at the start bit and presents
// one bit per strobe on sdo; shows the ready bit when no frame runs.
// Assumes load only occurs while the port is idle.
module dbgport_tx #(
    parameter int WORD_W = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load,
    input  logic [WORD_W+dbgport_pkg::HDR_BITS-1:0] load_word,
    input  logic                                  shift,
    input  logic                                  busy,
    input  logic                                  ready,
    output logic                                  sdo
);
    localparam int OUT_BITS = WORD_W + dbgport_pkg::HDR_BITS;

    logic [OUT_BITS-1:0] sr_q;

    // Load the reply at the start bit, then shift it left per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_word;
        end else if (shift) begin
            sr_q <= {sr_q[OUT_BITS-2:0], 1'b0};
        end
    end

    // The serial line carries reply bits in a frame, the ready bit otherwise.
    assign sdo = busy ? sr_q[OUT_BITS-1] : ready;

    // R10
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (ready && !busy));
endmodule

// File: rtl/dbgport_ctl.sv
// Sequencer control: picks the reply status and holds the error latches,
// the CPU word buffer and the CPU-side response and bus-error pulses.
// Assumes the CPU holds cpu_req_valid until a response or bus error.
module dbgport_ctl
    import dbgport_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic                       busy,
    input  logic                       done,
    input  logic                       mode,
    input  logic                       ctrl,
    input  logic [WORD_W-1:0]          payload,
    input  logic                       cpu_req_valid,
    input  logic                       cpu_req_is_data,
    input  logic                       cpu_wr_valid,
    input  logic [WORD_W-1:0]          cpu_wr_word,
    input  logic                       cpu_exc,
    input  logic                       exc_enable,
    output logic [WORD_W+HDR_BITS-1:0] tx_word,
    output logic                       ready,
    output logic                       cpu_rsp_valid,
    output logic [WORD_W-1:0]          cpu_rsp_word,
    output logic                       cpu_bus_err
);
    logic              seq_q;
    logic              exc_q;
    logic              exc_cpu_q;
    logic              buf_v_q;
    logic [WORD_W-1:0] buf_w_q;
    dp_status_e        rep_q;
    dp_status_e        st_sel;
    logic              rsp_v_q;
    logic [WORD_W-1:0] rsp_w_q;
    logic              berr_q;

    // Status priority: sequencing error, exception, CPU data, null.
    always_comb begin
        if (seq_q)        st_sel = ST_SEQERR;
        else if (exc_q)   st_sel = ST_EXC;
        else if (buf_v_q) st_sel = ST_DATA;
        else              st_sel = ST_NULL;
    end

    // The reply word is the buffered CPU word only with data status.
    assign tx_word = {st_sel, (st_sel == ST_DATA) ? buf_w_q : '0};

    // Ready once prior activity has finished and something awaits the host.
    assign ready = !busy && !done && !rsp_v_q && !berr_q
                   && (cpu_req_valid || seq_q || exc_q);

    // Latch updates, buffer handling and end-of-frame CPU actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q     <= 1'b0;
            exc_q     <= 1'b0;
            exc_cpu_q <= 1'b0;
            buf_v_q   <= 1'b0;
            buf_w_q   <= '0;
            rep_q     <= ST_NULL;
            rsp_v_q   <= 1'b0;
            rsp_w_q   <= '0;
            berr_q    <= 1'b0;
        end else begin
            rsp_v_q <= 1'b0;
            berr_q  <= 1'b0;
            if (frame_start) begin
                rep_q <= st_sel;
                if (st_sel == ST_DATA) buf_v_q <= 1'b0;
            end
            if (cpu_wr_valid) begin
                buf_v_q <= 1'b1;
                buf_w_q <= cpu_wr_word;
            end
            if (cpu_exc && exc_enable) begin
                exc_q     <= 1'b1;
                exc_cpu_q <= 1'b1;
            end
            if (done) begin
                case (rep_q)
                    ST_SEQERR: begin
                        seq_q     <= 1'b0;
                        exc_q     <= 1'b1;
                        exc_cpu_q <= 1'b0;
                    end
                    ST_EXC: begin
                        exc_q     <= 1'b0;
                        exc_cpu_q <= 1'b0;
                        if (exc_cpu_q && cpu_req_valid) berr_q <= 1'b1;
                    end
                    default: begin
                        if (!mode && cpu_req_valid) begin
                            if (ctrl == cpu_req_is_data) begin
                                rsp_v_q <= 1'b1;
                                rsp_w_q <= payload;
                            end else begin
                                berr_q <= 1'b1;
                                seq_q  <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    assign cpu_rsp_valid = rsp_v_q;
    assign cpu_rsp_word  = rsp_w_q;
    assign cpu_bus_err   = berr_q;

    // R5
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_v_q, berr_q}));

    // R3
    rsp_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_v_q |-> $past(cpu_req_valid));

    // R6
    seq_to_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q) |-> exc_q);

    // R5
    seq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q) |-> berr_q);
endmodule

// File: rtl/dbgport_seq.sv
// Top: debug port transmission sequencer joining receiver, control and
// reply shifter. Assumes shift_en is already in the clk domain.
module dbgport_seq #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdi,
    output logic              sdo,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_is_data,
    output logic              cpu_rsp_valid,
    output logic [WORD_W-1:0] cpu_rsp_word,
    output logic              cpu_bus_err,
    input  logic              cpu_wr_valid,
    input  logic [WORD_W-1:0] cpu_wr_word,
    input  logic              cpu_exc,
    input  logic              exc_enable
);
    localparam int OUT_BITS = WORD_W + dbgport_pkg::HDR_BITS;

    logic              frame_start;
    logic              busy;
    logic              done;
    logic              mode;
    logic              ctrl;
    logic [WORD_W-1:0] payload;
    logic              ready;
    logic [OUT_BITS-1:0] tx_word;

    dbgport_frame_rx #(.WORD_W(WORD_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en    (shift_en),
        .sdi         (sdi),
        .ready       (ready),
        .frame_start (frame_start),
        .busy        (busy),
        .done        (done),
        .mode        (mode),
        .ctrl        (ctrl),
        .payload     (payload)
    );

    dbgport_ctl #(.WORD_W(WORD_W)) u_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_start     (frame_start),
        .busy            (busy),
        .done            (done),
        .mode            (mode),
        .ctrl            (ctrl),
        .payload         (payload),
        .cpu_req_valid   (cpu_req_valid),
        .cpu_req_is_data (cpu_req_is_data),
        .cpu_wr_valid    (cpu_wr_valid),
        .cpu_wr_word     (cpu_wr_word),
        .cpu_exc         (cpu_exc),
        .exc_enable      (exc_enable),
        .tx_word         (tx_word),
        .ready           (ready),
        .cpu_rsp_valid   (cpu_rsp_valid),
        .cpu_rsp_word    (cpu_rsp_word),
        .cpu_bus_err     (cpu_bus_err)
    );

    dbgport_tx #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_start),
        .load_word (tx_word),
        .shift     (busy && shift_en),
        .busy      (busy),
        .ready     (ready),
        .sdo       (sdo)
    );
endmodule

// File: tb/dbgport_seq_bench.sv
// Bench: drives framed transmissions and checks replies and CPU pulses.
module dbgport_seq_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0;
    logic         sdi = 1'b0;
    logic         sdo;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_is_data = 1'b0;
    logic         cpu_rsp_valid;
    logic [W-1:0] cpu_rsp_word;
    logic         cpu_bus_err;
    logic         cpu_wr_valid = 1'b0;
    logic [W-1:0] cpu_wr_word = '0;
    logic         cpu_exc = 1'b0;
    logic         exc_enable = 1'b0;

    int total = 0;
    int bad = 0;
    int n_rsp = 0;
    int n_berr = 0;
    logic [W-1:0] last_word = '0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dbgport_seq #(.WORD_W(W)) u_dbgport_seq (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi), .sdo(sdo),
        .cpu_req_valid(cpu_req_valid), .cpu_req_is_data(cpu_req_is_data),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_word(cpu_rsp_word),
        .cpu_bus_err(cpu_bus_err), .cpu_wr_valid(cpu_wr_valid),
        .cpu_wr_word(cpu_wr_word), .cpu_exc(cpu_exc), .exc_enable(exc_enable)
    );

    // Count CPU-side pulses away from the active edge.
    always @(negedge clk) begin
        if (cpu_rsp_valid) begin
            n_rsp <= n_rsp + 1;
            last_word <= cpu_rsp_word;
        end
        if (cpu_bus_err) n_berr <= n_berr + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_bit(input logic b, output logic seen);
        @(negedge clk);
        seen = sdo;
        sdi = b;
        shift_en = 1'b1;
        @(negedge clk);
        shift_en = 1'b0;
        sdi = 1'b0;
    endtask

    // One full transmission with checks on reply and CPU-side outcome.
    task automatic run_frame(input string tag, input logic m, input logic c,
                             input logic [W-1:0] p, input logic [1:0] exp_st,
                             input logic [W-1:0] exp_out, input int exp_rsp,
                             input int exp_berr);
        logic [W+1:0] got;
        logic seen;
        int r0, b0;
        r0 = n_rsp;
        b0 = n_berr;
        do_bit(1'b1, seen);
        chk({tag, " R10 ready before start"}, 64'(seen), 64'd1);
        do_bit(m, got[W+1]);
        do_bit(c, got[W]);
        for (int i = W - 1; i >= 0; i--) do_bit(p[i], got[i]);
        // Back in the cycle after the last strobe: ready must be low.
        chk({tag, " R10 ready low after frame"}, 64'(sdo), 64'd0);
        repeat (3) @(negedge clk);
        chk({tag, " R2 status"}, 64'(got[W+1:W]), 64'(exp_st));
        chk({tag, " R2 reply word"}, 64'(got[W-1:0]), 64'(exp_out));
        chk({tag, " response count"}, 64'(n_rsp - r0), 64'(exp_rsp));
        chk({tag, " bus error count"}, 64'(n_berr - b0), 64'(exp_berr));
        if (exp_rsp == 1) chk({tag, " response word"}, 64'(last_word), 64'(p));
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(negedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic seen;
        logic [W-1:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R10: idle with no request shows not-ready
        chk("R1 idle sdo", 64'(sdo), 64'd0);

        cpu_req_valid = 1'b1;
        cpu_req_is_data = 1'b0;
        @(negedge clk);
        chk("R10 ready with request", 64'(sdo), 64'd1);
        run_frame("R1 R3 first", 1'b0, 1'b0, 32'hC0DE_0001, 2'b11, '0, 1, 0);

        // R8: CPU word reported once, then null; R4 data read served
        cpu_req_is_data = 1'b1;
        cpu_wr_word = 32'h5A5A_F00D;
        cpu_wr_valid = 1'b1;
        @(negedge clk);
        cpu_wr_valid = 1'b0;
        run_frame("R8 R4 data", 1'b0, 1'b1, 32'h0BAD_CAFE, 2'b00, 32'h5A5A_F00D, 1, 0);
        run_frame("R8 after", 1'b0, 1'b1, 32'h1357_9BDF, 2'b11, '0, 1, 0);

        // Sweep request kind, mode and control bit over several payloads
        for (int k = 0; k < 2; k++) begin
            for (int m = 0; m < 2; m++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int q = 0; q < 3; q++) begin
                        pat = 32'h9E37_79B9 * (k * 12 + m * 6 + c * 3 + q + 1);
                        cpu_req_is_data = k[0];
                        if (m == 1) begin
                            // R9: mode-1 frame, no CPU action
                            run_frame("R9 mode1", 1'b1, c[0], pat, 2'b11, '0, 0, 0);
                        end else if (c == k) begin
                            run_frame("R3 R4 match", 1'b0, c[0], pat, 2'b11, '0, 1, 0);
                        end else begin
                            run_frame("R5 mismatch", 1'b0, c[0], pat, 2'b11, '0, 0, 1);
                            run_frame("R5 seq report", 1'b0, 1'b0, ~pat, 2'b01, '0, 0, 0);
                            run_frame("R6 exc report", 1'b0, 1'b0, pat ^ 32'hFFFF, 2'b10, '0, 0, 0);
                        end
                    end
                end
            end
        end
        // R9: pending request survives mode-1 frame
        cpu_req_is_data = 1'b0;
        run_frame("R9 setup", 1'b1, 1'b0, 32'h2222_3333, 2'b11, '0, 0, 0);
        run_frame("R9 served", 1'b0, 1'b0, 32'h4444_5555, 2'b11, '0, 1, 0);

        // R7: enabled CPU exception ends pending access with bus error
        exc_enable = 1'b1;
        cpu_exc = 1'b1;
        @(negedge clk);
        cpu_exc = 1'b0;
        run_frame("R7 enabled", 1'b0, 1'b0, 32'hDEAD_BEEF, 2'b10, '0, 0, 1);
        run_frame("R7 resume", 1'b0, 1'b0, 32'h7777_0000, 2'b11, '0, 1, 0);

        // R7: disabled exception has no effect
        exc_enable = 1'b0;
        cpu_exc = 1'b1;
        @(negedge clk);
        cpu_exc = 1'b0;
        run_frame("R7 disabled", 1'b0, 1'b0, 32'h0F0F_0F0F, 2'b11, '0, 1, 0);

        // R7/R10: exception with no pending request, no bus error
        cpu_req_valid = 1'b0;
        @(negedge clk);
        chk("R10 idle no request", 64'(sdo), 64'd0);
        exc_enable = 1'b1;
        cpu_exc = 1'b1;
        @(negedge clk);
        cpu_exc = 1'b0;
        @(negedge clk);
        chk("R10 ready from latch", 64'(sdo), 64'd1);
        run_frame("R7 no request", 1'b0, 1'b0, 32'h1111_2222, 2'b10, '0, 0, 0);
        chk("R10 idle after report", 64'(sdo), 64'd0);

        // R10: start bit while not ready is ignored
        do_bit(1'b1, seen);
        chk("R10 not ready at stray start", 64'(seen), 64'd0);
        repeat (2) @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_is_data = 1'b0;
        @(negedge clk);
        run_frame("R10 after stray", 1'b0, 1'b0, 32'h8000_0001, 2'b11, '0, 1, 0);

        report();
    end
endmodule